// File: doc/BRIEF.md
# Status Register Write Guard

This block keeps the protection state of a byte-addressed nonvolatile array and decides, cycle by cycle, whether a write to the array or to the status byte may proceed. It holds three kinds of state. The first is a write-enable latch. The second is a two-bit block-protect field that picks which upper part of the array is locked. The third is a protect-enable bit that arms an external active-low write-protect pin. The nonvolatile bits are held in ordinary flops with a reset value.

A command decoder next to the block pulses the latch set and clear inputs and presents status-write requests with their data. It also reports a finished array write and drives the busy flag of the internal write cycle. The decoder presents a target address and reads the two permission outputs. The status byte can be read at any time, and its busy bit follows the live busy input.

Top module: `sr_guard`

## Requirements
- R1: After reset the status byte reads 0x00 with busy low, and both permission outputs are 0.
- R2: The status byte has protect-enable at bit 7, zeros at bits 6:4, the block-protect field at bits 3:2, the latch at bit 1 and the live busy input at bit 0.
- R3: A latch set pulse sets the latch and a latch clear pulse clears it, even while the status byte is pin-protected. When both arrive in the same cycle, the clear wins.
- R4: While the latch is 0, both permission outputs are 0 and a status-write request leaves the status byte unchanged.
- R5: A status write is accepted when the latch is 1, busy is low, and either protect-enable is 0 or the pin is high. With protect-enable at 0, the pin level does not matter. On acceptance, bits 7 and 3:2 of the data load at the next edge, the other data bits are ignored, and the latch clears.
- R6: With protect-enable at 1 and the pin low, a status-write request is refused. The status byte and the latch stay unchanged, and array writes to unprotected addresses remain allowed.
- R7: For a depth of N bytes, the block-protect field protects addresses as follows: 00 protects none, 01 protects addresses of 3N/4 and above, 10 protects addresses of N/2 and above, and 11 protects the whole array. The array-write permission is 0 for a protected address.
- R8: An array-write-done pulse clears the latch.
- R9: While busy is high, both permission outputs are 0 and status-write requests are ignored.
- R10: The pin is sampled at the edge that accepts a status write. A pin change after that edge does not undo the accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wel_set_i | input | 1 | Set the write-enable latch |
| wel_clr_i | input | 1 | Clear the write-enable latch |
| sr_wr_req_i | input | 1 | Status-write request |
| sr_wr_data_i | input | 8 | Status-write data |
| array_wr_done_i | input | 1 | An array write completed |
| busy_i | input | 1 | Internal write cycle in progress |
| wp_pin_i | input | 1 | Write-protect pin, low protects |
| chk_addr_i | input | AW | Array address to check |
| status_o | output | 8 | Status byte |
| array_wr_ok_o | output | 1 | Array write allowed at chk_addr_i |
| status_wr_ok_o | output | 1 | Status write allowed |

## Verification
The bench builds two copies of the block. The first uses a depth of 1024 bytes and the second a depth of 32768 bytes, and both receive the same command stimulus. The small copy reaches the quarter boundary at 0x300 and the half boundary at 0x200. The large copy reaches the same boundaries at 0x6000 and 0x4000, which shows that the region decode scales with the address width rather than being fixed. Each boundary is probed on both sides.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int unsigned SR_PE  = 7;
  localparam int unsigned SR_BP1 = 3;
  localparam int unsigned SR_BP0 = 2;
  localparam int unsigned SR_WEL = 1;
  localparam int unsigned SR_BSY = 0;

  typedef enum logic [1:0] {
    BP_NONE  = 2'b00,
    BP_QUART = 2'b01,
    BP_HALF  = 2'b10,
    BP_ALL   = 2'b11
  } bp_e;
endpackage

// File: rtl/sr_wel.sv
module sr_wel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wel_o <= 1'b0;
    else if (clr_i)  wel_o <= 1'b0;
    else if (set_i)  wel_o <= 1'b1;
  end

  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> wel_o);
  assert_clr_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !wel_o);
endmodule

// File: rtl/sr_nv.sv
module sr_nv
  import sr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic pe_d_i,
  input  bp_e  bp_d_i,
  output logic pe_o,
  output bp_e  bp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pe_o <= 1'b0;
      bp_o <= BP_NONE;
    end else if (load_i) begin
      pe_o <= pe_d_i;
      bp_o <= bp_d_i;
    end
  end

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(pe_o) && $stable(bp_o)));
endmodule

// File: rtl/sr_region.sv
module sr_region
  import sr_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr_i,
  input  bp_e           bp_i,
  output logic          hit_o
);
  localparam logic [AW-1:0] QTR_BASE  = AW'(DEPTH - DEPTH / 4);
  localparam logic [AW-1:0] HALF_BASE = AW'(DEPTH / 2);

  always_comb begin
    unique case (bp_i)
      BP_NONE:  hit_o = 1'b0;
      BP_QUART: hit_o = (addr_i >= QTR_BASE);
      BP_HALF:  hit_o = (addr_i >= HALF_BASE);
      default:  hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wel_set_i,
  input  logic          wel_clr_i,
  input  logic          sr_wr_req_i,
  input  logic [7:0]    sr_wr_data_i,
  input  logic          array_wr_done_i,
  input  logic          busy_i,
  input  logic          wp_pin_i,
  input  logic [AW-1:0] chk_addr_i,
  output logic [7:0]    status_o,
  output logic          array_wr_ok_o,
  output logic          status_wr_ok_o
);
  logic wel, pe, hit, hw_lock, sr_accept;
  bp_e  bp;
  logic unused_data;

  assign unused_data = ^{sr_wr_data_i[6:4], sr_wr_data_i[1:0]};

  // pin only matters once armed by protect-enable
  assign hw_lock        = pe && !wp_pin_i;
  assign status_wr_ok_o = wel && !busy_i && !hw_lock;
  assign sr_accept      = sr_wr_req_i && status_wr_ok_o;

  sr_wel u_wel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (wel_set_i),
    .clr_i (wel_clr_i || sr_accept || array_wr_done_i),
    .wel_o (wel)
  );

  sr_nv u_nv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(sr_accept),
    .pe_d_i(sr_wr_data_i[SR_PE]),
    .bp_d_i(bp_e'(sr_wr_data_i[SR_BP1:SR_BP0])),
    .pe_o  (pe),
    .bp_o  (bp)
  );

  sr_region #(.DEPTH(DEPTH)) u_region (
    .addr_i(chk_addr_i),
    .bp_i  (bp),
    .hit_o (hit)
  );

  assign array_wr_ok_o = wel && !busy_i && !hit;
  assign status_o      = {pe, 3'b000, bp, wel, busy_i};

  assert_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (!array_wr_ok_o && !status_wr_ok_o));
  assert_all_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[SR_BP1:SR_BP0] == 2'b11) |-> !array_wr_ok_o);
  assert_reject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_wr_req_i && status_o[SR_PE] && !wp_pin_i) |=> $stable(status_o[7:1]));
  assert_accept_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_wr_req_i && status_wr_ok_o) |=> !status_o[SR_WEL]);
  assert_no_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[SR_WEL] |-> (!array_wr_ok_o && !status_wr_ok_o));
endmodule

// File: tb/sim_sr_guard.sv
module sim_sr_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wel_set = 0, wel_clr = 0, sr_req = 0, wr_done = 0, busy = 0, pin = 1;
  logic [7:0]  sr_data = 0;
  logic [9:0]  addr0 = 0;
  logic [14:0] addr1 = 0;
  logic [7:0]  st0, st1;
  logic aok0, sok0, aok1, sok1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sr_guard #(.DEPTH(1024)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wel_set_i(wel_set), .wel_clr_i(wel_clr),
    .sr_wr_req_i(sr_req), .sr_wr_data_i(sr_data), .array_wr_done_i(wr_done),
    .busy_i(busy), .wp_pin_i(pin), .chk_addr_i(addr0),
    .status_o(st0), .array_wr_ok_o(aok0), .status_wr_ok_o(sok0));

  sr_guard #(.DEPTH(32768)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wel_set_i(wel_set), .wel_clr_i(wel_clr),
    .sr_wr_req_i(sr_req), .sr_wr_data_i(sr_data), .array_wr_done_i(wr_done),
    .busy_i(busy), .wp_pin_i(pin), .chk_addr_i(addr1),
    .status_o(st1), .array_wr_ok_o(aok1), .status_wr_ok_o(sok1));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); #1; endtask
  task automatic set_wel(); wel_set = 1; @(negedge clk); wel_set = 0; #1; endtask
  task automatic clr_wel(); wel_clr = 1; @(negedge clk); wel_clr = 0; #1; endtask
  task automatic sr_write(logic [7:0] d);
    sr_data = d; sr_req = 1; @(negedge clk); sr_req = 0; #1;
  endtask

  task automatic t_reset();
    chk("R1 status", st0, 8'h00);
    chk("R1 array ok", aok0, 0);
    chk("R1 status ok", sok0, 0);
  endtask

  task automatic t_locked();
    sr_write(8'h8C);
    chk("R4 status unchanged", st0, 8'h00);
    addr0 = 0;
    chk("R4 array ok", aok0, 0);
  endtask

  task automatic t_layout_busy();
    set_wel();
    chk("R2 wel at bit1", st0, 8'h02);
    busy = 1; #1;
    chk("R2 busy at bit0", st0, 8'h03);
    chk("R9 array ok", aok0, 0);
    chk("R9 status ok", sok0, 0);
    sr_write(8'h0C);
    chk("R9 write ignored", st0, 8'h03);
    busy = 0; #1;
  endtask

  task automatic t_sr_write();
    sr_write(8'h74);
    chk("R5 load and clear", st0, 8'h04);
  endtask

  task automatic t_regions();
    set_wel();
    addr0 = 10'h2FF; addr1 = 15'h5FFF; #1;
    chk("R7 quarter below u0", aok0, 1);
    chk("R7 quarter below u1", aok1, 1);
    addr0 = 10'h300; addr1 = 15'h6000; #1;
    chk("R7 quarter at u0", aok0, 0);
    chk("R7 quarter at u1", aok1, 0);
    sr_write(8'h08); set_wel();
    addr0 = 10'h1FF; addr1 = 15'h3FFF; #1;
    chk("R7 half below u0", aok0, 1);
    chk("R7 half below u1", aok1, 1);
    addr0 = 10'h200; addr1 = 15'h4000; #1;
    chk("R7 half at u0", aok0, 0);
    chk("R7 half at u1", aok1, 0);
    sr_write(8'h0C); set_wel();
    addr0 = 10'h000; #1;
    chk("R7 all", aok0, 0);
    sr_write(8'h00); set_wel();
    addr0 = 10'h3FF; #1;
    chk("R7 none", aok0, 1);
  endtask

  task automatic t_pin_guard();
    sr_write(8'h80);
    chk("R5 pe set", st0, 8'h80);
    set_wel();
    pin = 0; #1;
    chk("R6 status ok low", sok0, 0);
    sr_write(8'h0C);
    chk("R6 refused, latch kept", st0, 8'h82);
    addr0 = 10'h3FF; #1;
    chk("R6 array still ok", aok0, 1);
    clr_wel();
    chk("R3 clear while protected", st0, 8'h80);
    set_wel();
    chk("R3 set while protected", st0, 8'h82);
    wel_set = 1; wel_clr = 1; @(negedge clk); wel_set = 0; wel_clr = 0; #1;
    chk("R3 clear wins", st0, 8'h80);
    set_wel();
    pin = 1; #1;
    chk("R5 pin high allows", sok0, 1);
  endtask

  task automatic t_pin_timing();
    sr_data = 8'h84; sr_req = 1;
    @(negedge clk);
    sr_req = 0; pin = 0; #1;
    chk("R10 accepted write held", st0, 8'h84);
    pin = 1;
    set_wel();
    sr_write(8'h00);
    chk("R5 pe cleared", st0, 8'h00);
    set_wel();
    pin = 0;
    sr_write(8'h08);
    chk("R5 pin ignored when pe 0", st0, 8'h08);
    pin = 1; #1;
  endtask

  task automatic t_array_done();
    set_wel();
    chk("R8 latch set", st0, 8'h0A);
    wr_done = 1; @(negedge clk); wr_done = 0; #1;
    chk("R8 done clears latch", st0, 8'h08);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_locked();
    t_layout_busy();
    t_sr_write();
    t_regions();
    t_pin_guard();
    t_pin_timing();
    t_array_done();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule